// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator with End-of-Interrupt Handshake

This block collects the pending flags of a bank of general-purpose pins and turns them into two things. The first is a summary word that software reads as a low and a high 32-bit register. Each summary bit stands for a group of four neighbouring pins, so a handler can find the active group quickly and then scan only those four pins. The second is a single shared interrupt line to the host. Once the line rises it stays high until software writes an end-of-interrupt (EOI) bit in a master control register. The line then drops for one cycle so that the host sees a fresh edge for any work that is still outstanding.

The master register also holds a status-blocking feature. When blocking is enabled, any write to any pin's debounce settings opens a window that lasts a programmed number of slow-clock ticks. While the window is open, the per-pin detectors are told to produce no new wake or interrupt status, and every pin's interrupt-enable bit reads back as zero. Software polls that read-back to learn when the window has closed.

Top module: `irq_summary_agg`

## Requirements
- R1: After reset, `host_irq`, `status_block`, `sum_lo`, `sum_hi` and `mst_rdata` are all 0.
- R2: One cycle after the pending flags are presented, summary bit n is the OR of `pin_pending[4n+3:4n]`, for n from 0 to 45. Bits 0–31 appear on `sum_lo[31:0]` and bits 32–45 on `sum_hi[13:0]`. The mask has no effect on the summary.
- R3: `sum_hi[31:14]` (summary bits 46–63) always reads 0.
- R4: From the idle state, `host_irq` rises in the cycle after some pin has both `pin_pending` and `pin_unmasked` set. A pending pin whose unmask bit is 0 does not raise it.
- R5: Once `host_irq` is high it stays high, even if every pending flag clears, until an EOI write.
- R6: An EOI write is a cycle with `mst_wr` and `mst_weoi` both at 1. An EOI write while `host_irq` is high drives it low for exactly one cycle. After that cycle it is high again if an unmasked pending flag is present, and low otherwise. An EOI write while the line is idle has no effect.
- R7: A cycle with `mst_wr` at 1 loads the length field (`mst_rdata[11:0]`) from `mst_wlen` and the blocking-enable bit (`mst_rdata[16]`) from `mst_wen`. The EOI bit position, `mst_rdata[29]`, always reads 0, and every other bit reads 0.
- R8: With blocking enabled, a `dbnc_wr` cycle opens the window. `status_block` is high from the next cycle and falls after exactly L `slow_tick` pulses, where L is the length field. A length of 0 opens no window.
- R9: A `dbnc_wr` during an open window reloads the count, so the window ends L ticks after the latest write.
- R10: With blocking disabled, `dbnc_wr` leaves `status_block` at 0.
- R11: `pin_irq_en_rd` is all zeros while `status_block` is high, and equals `pin_irq_en` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period; drives the blocking count |
| pin_pending | input | 184 | Per-pin pending flags from the detectors |
| pin_unmasked | input | 184 | Per-pin delivery enables; 1 lets a pending flag reach the host line |
| pin_irq_en | input | 184 | Per-pin interrupt-enable bits as stored |
| dbnc_wr | input | 1 | Pulse: software wrote some pin's debounce fields |
| mst_wr | input | 1 | Master register write strobe |
| mst_wlen | input | 12 | Write data for the blocking length field |
| mst_wen | input | 1 | Write data for the blocking-enable bit |
| mst_weoi | input | 1 | Write data for the self-clearing EOI bit |
| mst_rdata | output | 32 | Master register read value |
| sum_lo | output | 32 | Summary bits 31:0 |
| sum_hi | output | 32 | Summary bits 63:32 |
| host_irq | output | 1 | Shared interrupt line to the host |
| status_block | output | 1 | High while the status-blocking window is open |
| pin_irq_en_rd | output | 184 | Interrupt-enable read-back, forced to 0 during the window |

## Verification
The summary is driven with sparse random pending vectors from a fixed seed. These leave most groups empty and some with one or several pins set, which shows whether each group ORs exactly its own four pins. Directed cases place flags in the first group and the last valid group (bit 45 on the high word) to find off-by-one errors at the word split. The host line is exercised with a masked pending pin, a pending flag that clears before EOI, and an EOI that arrives with work still pending. These separate masking, the hold behaviour and the one-cycle gap. The blocking timer is run with length zero, with blocking disabled, with a plain window and with a restart mid-window. Gaps without ticks show that only slow ticks advance the count.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  localparam int REG_W   = 32;
  localparam int EN_BIT  = 16;
  localparam int EOI_BIT = 29;

  typedef enum logic [1:0] {
    LINE_IDLE   = 2'd0,
    LINE_ACTIVE = 2'd1,
    LINE_GAP    = 2'd2
  } line_state_e;
endpackage

// File: rtl/irq_sum_tree.sv
module irq_sum_tree #(
  parameter int NUM_GROUPS = 46,
  parameter int GROUP_SIZE = 4,
  parameter int SUM_W      = 64,
  localparam int NUM_PINS  = NUM_GROUPS * GROUP_SIZE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pend,
  input  logic [NUM_PINS-1:0] unmask,
  output logic [SUM_W-1:0]    summary,
  output logic                any_live
);
  logic [SUM_W-1:0] grp_or;

  // One OR per group of pins; bits past the last group are tied low.
  for (genvar g = 0; g < SUM_W; g++) begin : g_grp
    if (g < NUM_GROUPS) begin : g_valid
      assign grp_or[g] = |pend[g*GROUP_SIZE +: GROUP_SIZE];
    end else begin : g_pad
      assign grp_or[g] = 1'b0;
    end
  end

  assign any_live = |(pend & unmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      summary <= '0;
    end else begin
      summary <= grp_or;
    end
  end
endmodule

// File: rtl/irq_eoi_ctrl.sv
module irq_eoi_ctrl
  import irq_sum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_live,
  input  logic eoi_req,
  output logic line
);
  line_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LINE_IDLE:   if (any_live) st_d = LINE_ACTIVE;
      LINE_ACTIVE: if (eoi_req)  st_d = LINE_GAP;
      LINE_GAP:    st_d = any_live ? LINE_ACTIVE : LINE_IDLE;
      default:     st_d = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LINE_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign line = (st_q == LINE_ACTIVE);
endmodule

// File: rtl/irq_blk_timer.sv
module irq_blk_timer #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign active = |cnt_q;

  // A new arm reloads the count even inside an open window.
  always_comb begin
    cnt_ce = arm | (tick & active);
    if (arm) begin
      cnt_d = len;
    end else begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_summary_agg.sv
module irq_summary_agg
  import irq_sum_pkg::*;
#(
  parameter int NUM_GROUPS = 46,
  parameter int GROUP_SIZE = 4,
  parameter int SUM_W      = 64,
  parameter int LEN_W      = 12,
  localparam int NUM_PINS  = NUM_GROUPS * GROUP_SIZE,
  localparam int HALF_W    = SUM_W / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slow_tick,
  input  logic [NUM_PINS-1:0] pin_pending,
  input  logic [NUM_PINS-1:0] pin_unmasked,
  input  logic [NUM_PINS-1:0] pin_irq_en,
  input  logic                dbnc_wr,
  input  logic                mst_wr,
  input  logic [LEN_W-1:0]    mst_wlen,
  input  logic                mst_wen,
  input  logic                mst_weoi,
  output logic [REG_W-1:0]    mst_rdata,
  output logic [HALF_W-1:0]   sum_lo,
  output logic [HALF_W-1:0]   sum_hi,
  output logic                host_irq,
  output logic                status_block,
  output logic [NUM_PINS-1:0] pin_irq_en_rd
);
  logic [SUM_W-1:0] summary;
  logic             any_live;
  logic             eoi_req;
  logic [LEN_W-1:0] cfg_len_q;
  logic             cfg_en_q;

  // Master control register: length and enable are stored, EOI is a strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_len_q <= '0;
      cfg_en_q  <= 1'b0;
    end else if (mst_wr) begin
      cfg_len_q <= mst_wlen;
      cfg_en_q  <= mst_wen;
    end
  end

  assign eoi_req = mst_wr & mst_weoi;

  always_comb begin
    mst_rdata                = '0;
    mst_rdata[LEN_W-1:0]     = cfg_len_q;
    mst_rdata[EN_BIT]        = cfg_en_q;
  end

  irq_sum_tree #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_SIZE (GROUP_SIZE),
    .SUM_W      (SUM_W)
  ) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pin_pending),
    .unmask   (pin_unmasked),
    .summary  (summary),
    .any_live (any_live)
  );

  assign sum_lo = summary[HALF_W-1:0];
  assign sum_hi = summary[SUM_W-1:HALF_W];

  irq_eoi_ctrl u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_live (any_live),
    .eoi_req  (eoi_req),
    .line     (host_irq)
  );

  irq_blk_timer #(
    .LEN_W (LEN_W)
  ) u_blk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (slow_tick),
    .arm    (dbnc_wr & cfg_en_q),
    .len    (cfg_len_q),
    .active (status_block)
  );

  assign pin_irq_en_rd = status_block ? '0 : pin_irq_en;
endmodule

// File: rtl/irq_summary_agg_chk.sv
module irq_summary_agg_chk
  import irq_sum_pkg::*;
#(
  parameter int NUM_GROUPS = 46,
  parameter int GROUP_SIZE = 4,
  parameter int LEN_W      = 12,
  localparam int NUM_PINS  = NUM_GROUPS * GROUP_SIZE
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_pending,
  input logic [NUM_PINS-1:0] pin_unmasked,
  input logic                dbnc_wr,
  input logic                mst_wr,
  input logic [LEN_W-1:0]    mst_wlen,
  input logic                mst_weoi,
  input logic [REG_W-1:0]    mst_rdata,
  input logic                host_irq,
  input logic                status_block,
  input logic [NUM_PINS-1:0] pin_irq_en_rd
);
  assert_line_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(|(pin_pending & pin_unmasked)));

  assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !(mst_wr && mst_weoi)) |=> host_irq);

  assert_eoi_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && mst_wr && mst_weoi) |=> !host_irq);

  assert_eoi_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_rdata[EOI_BIT]);

  assert_len_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mst_wr |=> (mst_rdata[LEN_W-1:0] == $past(mst_wlen)));

  assert_window_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbnc_wr && mst_rdata[EN_BIT] && (mst_rdata[LEN_W-1:0] != '0)) |=> status_block);

  assert_window_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_block) |-> $past(dbnc_wr));

  assert_window_stays_shut_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_block && !dbnc_wr) |=> !status_block);

  assert_en_hidden_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_block |-> (pin_irq_en_rd == '0));
endmodule

bind irq_summary_agg irq_summary_agg_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_SIZE (GROUP_SIZE),
  .LEN_W      (LEN_W)
) u_chk (.*);

// File: tb/irq_summary_agg_tb.sv
module irq_summary_agg_tb;
  localparam int NG = 46;
  localparam int GS = 4;
  localparam int NP = NG * GS;
  localparam int LW = 12;

  logic          clk;
  logic          rst_n;
  logic          slow_tick;
  logic [NP-1:0] pin_pending, pin_unmasked, pin_irq_en;
  logic          dbnc_wr, mst_wr, mst_wen, mst_weoi;
  logic [LW-1:0] mst_wlen;
  logic [31:0]   mst_rdata, sum_lo, sum_hi;
  logic          host_irq, status_block;
  logic [NP-1:0] pin_irq_en_rd;

  int checks = 0;
  int errors = 0;

  irq_summary_agg u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .pin_pending(pin_pending), .pin_unmasked(pin_unmasked), .pin_irq_en(pin_irq_en),
    .dbnc_wr(dbnc_wr), .mst_wr(mst_wr), .mst_wlen(mst_wlen), .mst_wen(mst_wen),
    .mst_weoi(mst_weoi), .mst_rdata(mst_rdata), .sum_lo(sum_lo), .sum_hi(sum_hi),
    .host_irq(host_irq), .status_block(status_block), .pin_irq_en_rd(pin_irq_en_rd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] exp_sum(input logic [NP-1:0] p);
    logic [63:0] s = '0;
    for (int g = 0; g < NG; g++) s[g] = |p[g*GS +: GS];
    return s;
  endfunction

  function automatic logic [NP-1:0] rnd_sparse();
    logic [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = (($urandom % 8) == 0);
    return v;
  endfunction

  task automatic wr_master(input logic [LW-1:0] len, input logic en, input logic eoi);
    mst_wr = 1'b1; mst_wlen = len; mst_wen = en; mst_weoi = eoi;
    step();
    mst_wr = 1'b0; mst_weoi = 1'b0;
  endtask

  task automatic slow_pulse();
    slow_tick = 1'b1;
    step();
    slow_tick = 1'b0;
  endtask

  task automatic dbnc_pulse();
    dbnc_wr = 1'b1;
    step();
    dbnc_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NP-1:0] p;
    logic [63:0]   e;
    void'($urandom(32'd20240407));
    rst_n = 1'b0; slow_tick = 1'b0; dbnc_wr = 1'b0;
    mst_wr = 1'b0; mst_wlen = '0; mst_wen = 1'b0; mst_weoi = 1'b0;
    pin_pending = '0; pin_unmasked = '0; pin_irq_en = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(host_irq == 1'b0, "R1 host_irq", 64'(host_irq), 64'd0);
    chk(status_block == 1'b0, "R1 status_block", 64'(status_block), 64'd0);
    chk({sum_hi, sum_lo} == 64'd0, "R1 summary", {sum_hi, sum_lo}, 64'd0);
    chk(mst_rdata == 32'd0, "R1 mst_rdata", 64'(mst_rdata), 64'd0);

    // R4 masked pending pin shows in summary but does not raise the line
    pin_pending[5] = 1'b1;
    step();
    chk(host_irq == 1'b0, "R4 masked pin", 64'(host_irq), 64'd0);
    chk(sum_lo == 32'h2, "R2 group 1 summary", 64'(sum_lo), 64'h2);
    pin_unmasked[5] = 1'b1;
    step();
    chk(host_irq == 1'b1, "R4 unmasked pin", 64'(host_irq), 64'd1);

    // R5 line holds after pending clears
    pin_pending = '0;
    step();
    chk(host_irq == 1'b1, "R5 hold 1", 64'(host_irq), 64'd1);
    step();
    chk(host_irq == 1'b1, "R5 hold 2", 64'(host_irq), 64'd1);

    // R6 EOI with nothing pending: gap then idle
    wr_master('0, 1'b0, 1'b1);
    chk(host_irq == 1'b0, "R6 gap", 64'(host_irq), 64'd0);
    step();
    chk(host_irq == 1'b0, "R6 idle after gap", 64'(host_irq), 64'd0);

    // R2/R6 last valid pin, EOI with work still pending
    pin_pending[NP-1] = 1'b1; pin_unmasked[NP-1] = 1'b1;
    step();
    chk(host_irq == 1'b1, "R4 last pin", 64'(host_irq), 64'd1);
    chk(sum_hi == 32'h2000, "R2 bit 45", 64'(sum_hi), 64'h2000);
    wr_master('0, 1'b0, 1'b1);
    chk(host_irq == 1'b0, "R6 gap pending", 64'(host_irq), 64'd0);
    step();
    chk(host_irq == 1'b1, "R6 reassert", 64'(host_irq), 64'd1);
    pin_pending = '0; pin_unmasked = '0;
    wr_master('0, 1'b0, 1'b1);
    step();
    chk(host_irq == 1'b0, "R6 final idle", 64'(host_irq), 64'd0);
    // EOI while idle has no effect on line
    pin_pending[0] = 1'b1; pin_unmasked[0] = 1'b1;
    wr_master('0, 1'b0, 1'b1);
    chk(host_irq == 1'b1, "R6 idle eoi ignored", 64'(host_irq), 64'd1);
    pin_pending = '0; pin_unmasked = '0;
    wr_master('0, 1'b0, 1'b1);
    step();

    // R2/R3 random summary patterns
    for (int it = 0; it < 40; it++) begin
      p = rnd_sparse();
      pin_pending = p;
      pin_unmasked = rnd_sparse();
      step();
      e = exp_sum(p);
      chk({sum_hi, sum_lo} == e, "R2 random summary", {sum_hi, sum_lo}, e);
      chk(sum_hi[31:14] == '0, "R3 unused bits", 64'(sum_hi[31:14]), 64'd0);
    end
    pin_pending = '0; pin_unmasked = '0;
    step();
    wr_master('0, 1'b0, 1'b1);
    step();

    // R7 register fields
    wr_master(12'd3, 1'b1, 1'b1);
    chk(mst_rdata == 32'h0001_0003, "R7 readback", 64'(mst_rdata), 64'h10003);
    chk(mst_rdata[29] == 1'b0, "R7 eoi reads 0", 64'(mst_rdata[29]), 64'd0);

    // R8/R11 plain window of 3 ticks
    pin_irq_en = rnd_sparse() | 1;
    dbnc_pulse();
    chk(status_block == 1'b1, "R8 window open", 64'(status_block), 64'd1);
    chk(pin_irq_en_rd == '0, "R11 enables hidden", pin_irq_en_rd[63:0], 64'd0);
    repeat (5) step();
    chk(status_block == 1'b1, "R8 no tick no change", 64'(status_block), 64'd1);
    slow_pulse();
    slow_pulse();
    chk(status_block == 1'b1, "R8 after 2 ticks", 64'(status_block), 64'd1);
    slow_pulse();
    chk(status_block == 1'b0, "R8 closed after 3", 64'(status_block), 64'd0);
    chk(pin_irq_en_rd == pin_irq_en, "R11 enables visible", pin_irq_en_rd[63:0], pin_irq_en[63:0]);

    // R9 restart inside the window
    dbnc_pulse();
    slow_pulse();
    slow_pulse();
    dbnc_pulse();
    slow_pulse();
    slow_pulse();
    chk(status_block == 1'b1, "R9 restarted", 64'(status_block), 64'd1);
    slow_pulse();
    chk(status_block == 1'b0, "R9 closed", 64'(status_block), 64'd0);

    // R8 zero length opens nothing
    wr_master(12'd0, 1'b1, 1'b0);
    dbnc_pulse();
    chk(status_block == 1'b0, "R8 zero length", 64'(status_block), 64'd0);

    // R10 blocking disabled
    wr_master(12'd4, 1'b0, 1'b0);
    chk(mst_rdata == 32'h4, "R7 disabled readback", 64'(mst_rdata), 64'h4);
    dbnc_pulse();
    chk(status_block == 1'b0, "R10 disabled", 64'(status_block), 64'd0);
    chk(pin_irq_en_rd == pin_irq_en, "R10 enables untouched", pin_irq_en_rd[63:0], pin_irq_en[63:0]);

    // R11 random read-back outside the window
    for (int it = 0; it < 20; it++) begin
      pin_irq_en = rnd_sparse();
      step();
      chk(pin_irq_en_rd == pin_irq_en, "R11 random passthrough", pin_irq_en_rd[63:0], pin_irq_en[63:0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule